// File: doc/BRIEF.md
# Debug Serial Port Controller

This block is a small register-mapped serial port intended for console and bring-up traffic. A processor reaches it through a plain 32-bit register bus with separate write and read strobes. The bus can set the line rate, enable or disable each direction, and move single bytes through a receive holding register and a transmit holding register. A single level-sensitive interrupt line reports any status flag that software has chosen to watch. The serial side carries frames of one start bit, eight data bits sent least significant bit first, no parity and one stop bit, all timed from a 16x oversampling tick.

The data path is a stream with one slot in each direction. The transmit ready flag acts as the ready of the transmit stream. A write to the transmit holding register is a valid beat, and a beat that arrives while ready is low is dropped. On the receive side the serial line cannot be stalled. The receive ready flag is the back-pressure, and a byte that completes while that flag is still set is discarded and counted as an overrun. Reading the receive holding register pops the slot.

The register window is 512 bytes wide, and the upper address bits are ignored, so the window repeats through the address space. The two identification words are fixed by parameters.

Top module: `dbg_uart`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0x0000_0A02: transmit ready (bit 1), transmitter empty (bit 9) and transmit buffer empty (bit 11) are set. The interrupt mask (offset 0x10) reads 0, irq is low and ser_tx is high.
- R2: Offset 0x40 returns the ID_WORD parameter (default 0x275B0940) and offset 0x44 returns ID_EXT (default 0). Offsets 0x04 (mode, 32 bits) and 0x20 (divisor) read back what was written. Only address bits [8:2] are decoded, so 0x220 aliases 0x20 and 0x210 aliases 0x10.
- R3: A write to offset 0x08 ORs the data into the interrupt mask, and a write to offset 0x0C clears the mask bits that are set in the data.
- R4: irq is high exactly when (status AND mask) is nonzero. It follows a status or mask change on the next cycle.
- R5: Control writes go to offset 0x00. Bit 4 enables the receiver, bit 5 disables it, bit 6 enables the transmitter and bit 7 disables it. When a disable bit and its enable bit are set in the same write, the disable wins. Both directions are disabled after reset.
- R6: The 16x tick fires once every divisor clocks, so one bit lasts 16 x divisor clocks. A divisor of 0 stops the tick, and a frame in progress then freezes.
- R7: A write to offset 0x1C while the transmitter is enabled and transmit ready is set clears status bits 1, 9 and 11. The next cycle starts the frame on ser_tx: a low start bit, the data LSB first, then a high stop bit. The three bits are set again once the stop bit ends. Writes made while the transmitter is disabled or busy are ignored.
- R8: A byte that completes while the receiver is enabled and receive ready (bit 0) is clear is loaded into the receive holding register (offset 0x18, low 8 bits). It also sets bit 0 and receive buffer full (bit 12).
- R9: A read of offset 0x18 clears status bits 0 and 12.
- R10: A byte that completes while bit 0 is still set sets overrun (bit 5), and the holding register keeps the older byte.
- R11: A byte whose stop bit is sampled low sets framing error (bit 6).
- R12: A control write with bit 8 set clears status bits 5, 6 and 7.
- R13: Bytes that complete while the receiver is disabled leave the status and holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address. Bits [8:2] are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe. Only needed for the side effect of reading the receive holding register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt: nonzero (status AND mask) |
| ser_rx | input | 1 | Serial receive line, idle high |
| ser_tx | output | 1 | Serial transmit line, idle high |

## Verification
The properties assume that bus_wr and bus_rd are single-cycle strobes that are never raised together. They also assume that ser_rx holds each bit for the full 16 x divisor clocks of the current divisor. The stimulus keeps within these limits. It issues one bus access at a time on the falling clock edge, and it changes ser_rx only on bit boundaries computed for a divisor of 1. It also never alters the divisor while a byte is arriving. A framing-error frame releases the line early enough that the receiver's start-bit recheck sees idle rather than a false start.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;
  localparam int WIN_AW = 9;
  typedef logic [WIN_AW-3:0] word_t;

  localparam word_t W_CTRL  = 7'h00;
  localparam word_t W_MODE  = 7'h01;
  localparam word_t W_IEN   = 7'h02;
  localparam word_t W_IDIS  = 7'h03;
  localparam word_t W_IMASK = 7'h04;
  localparam word_t W_STAT  = 7'h05;
  localparam word_t W_RHOLD = 7'h06;
  localparam word_t W_THOLD = 7'h07;
  localparam word_t W_BDIV  = 7'h08;
  localparam word_t W_ID    = 7'h10;
  localparam word_t W_IDX   = 7'h11;

  localparam int ST_RXRDY = 0;
  localparam int ST_TXRDY = 1;
  localparam int ST_OVR   = 5;
  localparam int ST_FRM   = 6;
  localparam int ST_PAR   = 7;
  localparam int ST_TXEMP = 9;
  localparam int ST_TXBE  = 11;
  localparam int ST_RXBF  = 12;

  localparam int CB_RXEN   = 4;
  localparam int CB_RXDIS  = 5;
  localparam int CB_TXEN   = 6;
  localparam int CB_TXDIS  = 7;
  localparam int CB_RSTST  = 8;

  localparam logic [31:0] SR_RESET = 32'h0000_0A02;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/dbg_uart_tick.sv
module dbg_uart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (div != '0) && (cnt_q >= div - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (div == '0)    cnt_q <= '0;
    else if (tick)         cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              line,
  output logic              done
);
  localparam int FRAME_N = DATA_W + 2;
  localparam int CNT_W   = $clog2(OS);
  localparam int BIT_W   = $clog2(FRAME_N);

  logic [FRAME_N-1:0] sh_q;
  logic [CNT_W-1:0]   ph_q;
  logic [BIT_W-1:0]   n_q;
  logic               busy_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      ph_q   <= '0;
      n_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        sh_q   <= {1'b1, data, 1'b0};
        ph_q   <= '0;
        n_q    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && tick) begin
        if (ph_q == CNT_W'(OS - 1)) begin
          ph_q <= '0;
          sh_q <= {1'b1, sh_q[FRAME_N-1:1]};
          if (n_q == BIT_W'(FRAME_N - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            n_q <= n_q + 1'b1;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign line = busy_q ? sh_q[0] : 1'b1;
  assign done = done_q;
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
  import dbg_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_in,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              ferr
);
  localparam int CNT_W = $clog2(OS);
  localparam int IDX_W = $clog2(DATA_W);

  logic [1:0]        sync_q;
  logic              ln;
  rx_state_e         st_q;
  logic [CNT_W-1:0]  ph_q;
  logic [IDX_W-1:0]  n_q;
  logic [DATA_W-1:0] sh_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              ferr_q;

  assign ln = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      st_q    <= RX_IDLE;
      ph_q    <= '0;
      n_q     <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      ferr_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], line_in};
      valid_q <= 1'b0;
      if (tick) begin
        case (st_q)
          RX_IDLE: begin
            if (!ln) begin
              st_q <= RX_START;
              ph_q <= '0;
            end
          end
          RX_START: begin
            if (ph_q == CNT_W'(OS / 2 - 1)) begin
              ph_q <= '0;
              n_q  <= '0;
              st_q <= ln ? RX_IDLE : RX_DATA;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (ph_q == CNT_W'(OS - 1)) begin
              ph_q <= '0;
              sh_q <= {ln, sh_q[DATA_W-1:1]};
              if (n_q == IDX_W'(DATA_W - 1)) st_q <= RX_STOP;
              else                           n_q  <= n_q + 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (ph_q == CNT_W'(OS - 1)) begin
              ph_q    <= '0;
              valid_q <= 1'b1;
              data_q  <= sh_q;
              ferr_q  <= !ln;
              st_q    <= RX_IDLE;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign ferr  = ferr_q;
endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
  import dbg_uart_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DIV_W   = 16,
  parameter int          DATA_W  = 8,
  parameter int          OS      = 16,
  parameter logic [31:0] ID_WORD = 32'h275B_0940,
  parameter logic [31:0] ID_EXT  = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              ser_rx,
  output logic              ser_tx
);
  word_t             word;
  logic              unused_addr;
  logic              rx_en_q, tx_en_q;
  logic [31:0]       mode_q, imr_q, sr_q, sr_d;
  logic [DATA_W-1:0] rhr_q;
  logic [DIV_W-1:0]  div_q;
  logic              tick, tx_done, tx_start;
  logic              rx_valid, rx_ferr, rx_take, rhr_rd, ctrl_wr;
  logic [DATA_W-1:0] rx_data;

  assign word        = bus_addr[WIN_AW-1:2];
  assign unused_addr = ^{bus_addr[ADDR_W-1:WIN_AW], bus_addr[1:0]};

  assign ctrl_wr  = bus_wr && (word == W_CTRL);
  assign rhr_rd   = bus_rd && (word == W_RHOLD);
  assign tx_start = bus_wr && (word == W_THOLD) && tx_en_q && sr_q[ST_TXRDY];
  assign rx_take  = rx_valid && rx_en_q && !(sr_q[ST_RXRDY] && !rhr_rd);

  dbg_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  dbg_uart_tx #(.DATA_W(DATA_W), .OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
    .data(bus_wdata[DATA_W-1:0]), .line(ser_tx), .done(tx_done)
  );

  dbg_uart_rx #(.DATA_W(DATA_W), .OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(ser_rx),
    .valid(rx_valid), .data(rx_data), .ferr(rx_ferr)
  );

  always_comb begin
    sr_d = sr_q;
    if (rhr_rd) begin
      sr_d[ST_RXRDY] = 1'b0;
      sr_d[ST_RXBF]  = 1'b0;
    end
    if (ctrl_wr && bus_wdata[CB_RSTST]) begin
      sr_d[ST_OVR] = 1'b0;
      sr_d[ST_FRM] = 1'b0;
      sr_d[ST_PAR] = 1'b0;
    end
    if (tx_start) begin
      sr_d[ST_TXRDY] = 1'b0;
      sr_d[ST_TXEMP] = 1'b0;
      sr_d[ST_TXBE]  = 1'b0;
    end
    if (tx_done) begin
      sr_d[ST_TXRDY] = 1'b1;
      sr_d[ST_TXEMP] = 1'b1;
      sr_d[ST_TXBE]  = 1'b1;
    end
    if (rx_valid && rx_en_q) begin
      if (rx_ferr) sr_d[ST_FRM] = 1'b1;
      if (rx_take) begin
        sr_d[ST_RXRDY] = 1'b1;
        sr_d[ST_RXBF]  = 1'b1;
      end else begin
        sr_d[ST_OVR] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      mode_q  <= '0;
      imr_q   <= '0;
      sr_q    <= SR_RESET;
      rhr_q   <= '0;
      div_q   <= '0;
    end else begin
      sr_q <= sr_d;
      if (rx_take) rhr_q <= rx_data;
      if (ctrl_wr) begin
        if (bus_wdata[CB_RXDIS])     rx_en_q <= 1'b0;
        else if (bus_wdata[CB_RXEN]) rx_en_q <= 1'b1;
        if (bus_wdata[CB_TXDIS])     tx_en_q <= 1'b0;
        else if (bus_wdata[CB_TXEN]) tx_en_q <= 1'b1;
      end
      if (bus_wr) begin
        case (word)
          W_MODE: mode_q <= bus_wdata;
          W_IEN:  imr_q  <= imr_q | bus_wdata;
          W_IDIS: imr_q  <= imr_q & ~bus_wdata;
          W_BDIV: div_q  <= bus_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (word)
      W_MODE:  bus_rdata = mode_q;
      W_IMASK: bus_rdata = imr_q;
      W_STAT:  bus_rdata = sr_q;
      W_RHOLD: bus_rdata = 32'(rhr_q);
      W_BDIV:  bus_rdata = 32'(div_q);
      W_ID:    bus_rdata = ID_WORD;
      W_IDX:   bus_rdata = ID_EXT;
      default: bus_rdata = 32'h0;
    endcase
  end

  assign irq = |(sr_q & imr_q);
endmodule

// File: rtl/dbg_uart_chk.sv
module dbg_uart_chk
  import dbg_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input word_t            word,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      imr_q,
  input logic             st_rxrdy,
  input logic             st_rxbf,
  input logic             st_ovr,
  input logic             st_frm,
  input logic             st_par,
  input logic             st_txemp,
  input logic             rx_en_q,
  input logic             tx_en_q,
  input logic             rx_valid,
  input logic             rx_ferr,
  input logic             tick,
  input logic             ser_tx,
  input logic [DIV_W-1:0] div_q
);
  assert_ien_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_IEN) |=> ((imr_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_idis_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_IDIS) |=> ((imr_q & $past(bus_wdata)) == 32'h0));

  assert_rxdis_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_CTRL && bus_wdata[CB_RXDIS]) |=> !rx_en_q);

  assert_txdis_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_CTRL && bus_wdata[CB_TXDIS]) |=> !tx_en_q);

  assert_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !tick);

  assert_idle_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_txemp |-> ser_tx);

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en_q && !st_rxrdy) |=> (st_rxrdy && st_rxbf));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && word == W_RHOLD && !(rx_valid && rx_en_q)) |=> (!st_rxrdy && !st_rxbf));

  assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en_q && st_rxrdy && !(bus_rd && word == W_RHOLD)) |=> st_ovr);

  assert_framing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en_q && rx_ferr) |=> st_frm);

  assert_rststa_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_CTRL && bus_wdata[CB_RSTST] && !(rx_valid && rx_en_q))
    |=> (!st_ovr && !st_frm && !st_par));

  assert_disabled_rx_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en_q && !st_rxrdy && !(bus_rd && word == W_RHOLD)) |=> !st_rxrdy);
endmodule

bind dbg_uart dbg_uart_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .word(word),
  .bus_wdata(bus_wdata), .imr_q(imr_q),
  .st_rxrdy(sr_q[0]), .st_rxbf(sr_q[12]), .st_ovr(sr_q[5]), .st_frm(sr_q[6]),
  .st_par(sr_q[7]), .st_txemp(sr_q[9]),
  .rx_en_q(rx_en_q), .tx_en_q(tx_en_q), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
  .tick(tick), .ser_tx(ser_tx), .div_q(div_q)
);

// File: tb/dbg_uart_tb.sv
module dbg_uart_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;

  typedef struct packed {
    logic              wr;
    logic [3:0]        req;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 4'd1, 12'h014, 32'h0000_0A02},  // R1 status after reset
    '{1'b0, 4'd1, 12'h010, 32'h0000_0000},  // R1 mask after reset
    '{1'b0, 4'd2, 12'h040, 32'h275B_0940},  // R2 id word
    '{1'b0, 4'd2, 12'h044, 32'h0000_0000},  // R2 id extension
    '{1'b1, 4'd2, 12'h004, 32'h0000_0800},  // R2 mode write
    '{1'b0, 4'd2, 12'h004, 32'h0000_0800},  // R2 mode readback
    '{1'b1, 4'd2, 12'h020, 32'h0000_0001},  // R2 divisor write
    '{1'b0, 4'd2, 12'h220, 32'h0000_0001},  // R2 divisor via alias
    '{1'b1, 4'd3, 12'h008, 32'h0000_1003},  // R3 enable strobe
    '{1'b0, 4'd3, 12'h010, 32'h0000_1003},  // R3 mask after enable
    '{1'b1, 4'd3, 12'h00C, 32'h0000_1001},  // R3 disable strobe
    '{1'b0, 4'd3, 12'h210, 32'h0000_0002}   // R3 mask after disable, aliased
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq;
  logic              ser_rx = 1'b1;
  logic              ser_tx;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbg_uart #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .ser_rx(ser_rx), .ser_tx(ser_tx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // One frame at divisor 1: 16 clocks per bit
  task automatic send(input logic [7:0] b, input logic good_stop);
    @(negedge clk);
    ser_rx = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (16) @(negedge clk);
    end
    if (good_stop) begin
      ser_rx = 1'b1;
      repeat (16) @(negedge clk);
    end else begin
      ser_rx = 1'b0;
      repeat (12) @(negedge clk);
      ser_rx = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    report();
  end

  initial begin
    logic [7:0] txb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'h0, ser_tx}, 32'h1);
    chk("R1", {31'h0, irq}, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k].wr) wr(VEC[k].addr, VEC[k].data);
      else rd_chk($sformatf("R%0d", VEC[k].req), VEC[k].addr, VEC[k].data);
    end

    // R4: mask bit 1 with transmit ready set raises irq
    chk("R4", {31'h0, irq}, 32'h1);

    // R5: transmit disable wins; R7: write while disabled ignored
    wr(12'h000, 32'h0000_00C0);
    wr(12'h01C, 32'h0000_003C);
    chk("R7", {31'h0, ser_tx}, 32'h1);
    rd_chk("R5", 12'h014, 32'h0000_0A02);

    // R7: frame shape, divisor 1
    wr(12'h000, 32'h0000_0040);
    txb = 8'hA5;
    wr(12'h01C, {24'h0, txb});
    chk("R7", {31'h0, ser_tx}, 32'h0);
    chk("R4", {31'h0, irq}, 32'h0);
    wr(12'h01C, 32'h0000_00FF);            // busy: must be ignored (R7)
    rd_chk("R7", 12'h014, 32'h0000_0000);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      chk("R7", {31'h0, ser_tx}, {31'h0, txb[i]});
    end
    repeat (16) @(negedge clk);
    chk("R7", {31'h0, ser_tx}, 32'h1);
    repeat (12) @(negedge clk);
    rd_chk("R7", 12'h014, 32'h0000_0A02);
    chk("R4", {31'h0, irq}, 32'h1);

    // R6: divisor 3 stretches bits to 48 clocks
    wr(12'h020, 32'h0000_0003);
    wr(12'h01C, 32'h0000_0001);
    repeat (24) @(negedge clk);
    chk("R6", {31'h0, ser_tx}, 32'h0);
    repeat (48) @(negedge clk);
    chk("R6", {31'h0, ser_tx}, 32'h1);
    repeat (440) @(negedge clk);
    rd_chk("R6", 12'h014, 32'h0000_0A02);

    // R6: divisor 0 freezes the frame
    wr(12'h020, 32'h0000_0000);
    wr(12'h01C, 32'h0000_0000);
    repeat (100) @(negedge clk);
    chk("R6", {31'h0, ser_tx}, 32'h0);
    rd_chk("R6", 12'h014, 32'h0000_0000);
    wr(12'h020, 32'h0000_0001);
    repeat (180) @(negedge clk);
    rd_chk("R6", 12'h014, 32'h0000_0A02);

    // Receive side, divisor 1; watch only receive ready
    wr(12'h00C, 32'h0000_0002);
    wr(12'h008, 32'h0000_0001);

    // R13: receiver disabled since reset
    send(8'h3C, 1'b1);
    rd_chk("R13", 12'h014, 32'h0000_0A02);
    chk("R13", {31'h0, irq}, 32'h0);

    // R5: receive disable wins over enable
    wr(12'h000, 32'h0000_0030);
    send(8'h3C, 1'b1);
    rd_chk("R5", 12'h014, 32'h0000_0A02);

    // R8 / R9
    wr(12'h000, 32'h0000_0010);
    send(8'h5A, 1'b1);
    rd_chk("R8", 12'h014, 32'h0000_1A03);
    chk("R4", {31'h0, irq}, 32'h1);
    rd_chk("R8", 12'h018, 32'h0000_005A);
    rd_chk("R9", 12'h014, 32'h0000_0A02);

    // R10: second byte while first unread
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    rd_chk("R10", 12'h014, 32'h0000_1A23);
    rd_chk("R10", 12'h018, 32'h0000_0011);

    // R11: low stop bit
    send(8'h77, 1'b0);
    rd_chk("R11", 12'h014, 32'h0000_1A63);
    rd_chk("R11", 12'h018, 32'h0000_0077);

    // R12: reset-status command
    wr(12'h000, 32'h0000_0100);
    rd_chk("R12", 12'h014, 32'h0000_0A02);

    report();
  end
endmodule